// File: doc/BRIEF.md
# Latched Interrupt Request Generator

This block collects fault events from the rest of the chip. It records each event in a status register that software can read, and it drives a single interrupt request toward the host. Each event input is a level signal, and its rising edge records a bit in the status register. A mask bit per event decides whether that event may disturb the request. The status register is read-only, and the read strobe clears every recorded bit at once.

Three request styles are available. A short pulse marks each new unmasked event. A pulse train starts on an unmasked event and repeats until the host reads the status. A level mode holds the request for as long as any unmasked recorded bit remains set, which suits a fault condition that persists. A polarity setting picks active-high or active-low signalling.

The request can also be presented as a pin that only ever pulls low, releasing otherwise. Several devices can then share one wired-AND interrupt net. The pad itself lies outside the block, which only supplies the drive level and the output enable.

Top module: `irq_latch_gen`

## Requirements
- R1: After reset, `stat_q` is all zeros and the request is inactive: `irq_o` equals the inverse of `pol_hi`, and with `od_en` low `pin_oe` is 1.
- R2: A rising edge on `evt_in[i]` sets `stat_q[i]`, visible from the cycle after the edge, whatever the mask. An event held high does not set the bit again after a clear.
- R3: A cycle with `stat_rd` high clears every bit of `stat_q` from the next cycle. A rising event edge in the same cycle as the read still sets its bit.
- R4: An event whose `mask` bit is 1 never activates the request, in any mode. A `mask` bit of 0 lets the event act. Reset values of the mask are the integrator's choice, and all ones masks everything.
- R5: While the request is active, `irq_o` equals `pol_hi`. While it is idle, `irq_o` equals the inverse of `pol_hi`.
- R6: With `mode` = 0, each unmasked rising event edge makes the request active for exactly 2 cycles, starting in the cycle after the edge. A new edge during the pulse restarts the 2 cycles.
- R7: With `mode` = 1, an unmasked rising event edge starts a train with period P = `period`, where values below 2 count as 2. The request is active in the first floor(P/2) cycles of each period, counted from the cycle after the edge. The train continues until a read and is idle from the cycle after the read.
- R8: With `mode` = 2 or 3, the request is active in every cycle where the status bits registered for that cycle, ANDed with the inverted `mask` of the previous cycle, are not all zero.
- R9: With `od_en` = 1, `pin_out` is 0 and `pin_oe` is 1 exactly while the request is active, whatever `pol_hi` is. With `od_en` = 0, `pin_oe` is 1 and `pin_out` equals `irq_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| evt_in | input | N_EVT | Fault event levels; rising edges are recorded |
| mask | input | N_EVT | Per-event mask, 1 blocks the request |
| pol_hi | input | 1 | 1 = active-high request, 0 = active-low |
| mode | input | 2 | 0 single pulse, 1 pulse train, 2/3 level |
| period | input | PER_W | Pulse-train period in cycles (minimum 2) |
| od_en | input | 1 | 1 = pull-low-only pin drive |
| stat_rd | input | 1 | Status read strobe, clears the status |
| stat_q | output | N_EVT | Recorded event status |
| irq_o | output | 1 | Request level after polarity |
| pin_out | output | 1 | Pin drive value |
| pin_oe | output | 1 | Pin output enable |

## Verification
Several rules are checked by the assertions on every cycle:
- status bits stay set until a read;
- a read with no event empties the status;
- a read stops a pulse train;
- a single pulse never lasts under two cycles;
- the level mode follows unmasked status;
- the pin never drives high in pull-low-only operation.

The exact pulse-train waveform for every period from 0 to 7 can only be shown by the bench scenarios. The same holds for the full sweep of mask and event combinations in level mode, for event-versus-read collisions, and for the polarity and pin-drive pairings.

// File: rtl/irq_latch_gen.sv
module irq_latch_gen #(
  parameter int N_EVT = 4,
  parameter int PER_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_EVT-1:0] evt_in,
  input  logic [N_EVT-1:0] mask,
  input  logic             pol_hi,
  input  logic [1:0]       mode,
  input  logic [PER_W-1:0] period,
  input  logic             od_en,
  input  logic             stat_rd,
  output logic [N_EVT-1:0] stat_q,
  output logic             irq_o,
  output logic             pin_out,
  output logic             pin_oe
);
  localparam logic [PER_W-1:0] MIN_PER = PER_W'(2);

  logic [N_EVT-1:0] evt_d, rise, stat_nxt;
  logic [PER_W-1:0] per_eff, half, ph_q, ph_nxt;
  logic             pcnt_q, pcnt_nxt, on_q, on_nxt, act_q, act_nxt, trig;

  assign rise     = evt_in & ~evt_d;
  assign trig     = |(rise & ~mask);
  assign stat_nxt = (stat_rd ? '0 : stat_q) | rise;
  assign per_eff  = (period < MIN_PER) ? MIN_PER : period;
  assign half     = per_eff >> 1;

  always_comb begin
    pcnt_nxt = 1'b0;
    on_nxt   = on_q;
    ph_nxt   = ph_q;
    if (trig) begin
      pcnt_nxt = 1'b1;
      on_nxt   = 1'b1;
      ph_nxt   = '0;
    end else begin
      if (stat_rd) on_nxt = 1'b0;
      else if (on_q) ph_nxt = (ph_q >= per_eff - 1'b1) ? '0 : ph_q + 1'b1;
    end
    unique case (mode)
      2'd0:    act_nxt = trig | pcnt_q;
      2'd1:    act_nxt = on_nxt && (ph_nxt < half);
      default: act_nxt = |(stat_nxt & ~mask);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_d  <= '0;
      stat_q <= '0;
      pcnt_q <= 1'b0;
      on_q   <= 1'b0;
      ph_q   <= '0;
      act_q  <= 1'b0;
    end else begin
      evt_d  <= evt_in;
      stat_q <= stat_nxt;
      pcnt_q <= pcnt_nxt;
      on_q   <= on_nxt;
      ph_q   <= ph_nxt;
      act_q  <= act_nxt;
    end
  end

  assign irq_o   = act_q ? pol_hi : ~pol_hi;
  assign pin_oe  = od_en ? act_q : 1'b1;
  assign pin_out = od_en ? 1'b0 : irq_o;
endmodule

module irq_latch_gen_chk #(
  parameter int N_EVT = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N_EVT-1:0] evt_in,
  input logic [N_EVT-1:0] mask,
  input logic [1:0]       mode,
  input logic             od_en,
  input logic             stat_rd,
  input logic [N_EVT-1:0] stat_q,
  input logic             pin_out,
  input logic             pin_oe,
  input logic             act_q
);
  // R2
  sticky_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_rd |=> ((stat_q & $past(stat_q)) == $past(stat_q)));
  // R3
  read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && evt_in == '0) |=> (stat_q == '0));
  // R7
  train_stops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd1 && stat_rd && evt_in == '0) |=> !act_q);
  // R6
  pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd0 && $rose(act_q)) |=> act_q);
  // R8
  level_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode[1] && !stat_rd && ((stat_q & ~mask) != '0)) |=> act_q);
  // R4
  level_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode[1] && (&mask)) |=> !act_q);
  // R9
  od_no_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    od_en |-> !(pin_oe && pin_out));
endmodule

bind irq_latch_gen irq_latch_gen_chk #(.N_EVT(N_EVT)) u_chk (
  .clk(clk), .rst_n(rst_n), .evt_in(evt_in), .mask(mask), .mode(mode),
  .od_en(od_en), .stat_rd(stat_rd), .stat_q(stat_q), .pin_out(pin_out),
  .pin_oe(pin_oe), .act_q(act_q)
);

// File: tb/irq_latch_gen_tb.sv
`timescale 1ns/1ps
module irq_latch_gen_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] evt_in = '0, mask = '0;
  logic       pol_hi = 1'b1, od_en = 1'b0, stat_rd = 1'b0;
  logic [1:0] mode = 2'd0;
  logic [7:0] period = 8'd4;
  logic [3:0] stat_q;
  logic       irq_o, pin_out, pin_oe;
  int total = 0, bad = 0;

  always #5 clk = ~clk;

  irq_latch_gen #(.N_EVT(4), .PER_W(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .evt_in(evt_in), .mask(mask), .pol_hi(pol_hi),
    .mode(mode), .period(period), .od_en(od_en), .stat_rd(stat_rd),
    .stat_q(stat_q), .irq_o(irq_o), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic pulse_evt(input logic [3:0] b);
    evt_in = b;
    tick();
    evt_in = '0;
  endtask

  task automatic clear_all();
    evt_in  = '0;
    stat_rd = 1'b1;
    tick();
    stat_rd = 1'b0;
    tick();
    tick();
  endtask

  function automatic int active();
    return (irq_o == pol_hi) ? 1 : 0;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 stat", stat_q, 0);
    check("R1 irq", irq_o, 0);
    check("R1 oe", pin_oe, 1);

    // R6 single pulse, two cycles wide
    mode = 2'd0; mask = 4'b0000;
    pulse_evt(4'b0100);
    check("R2 latch", stat_q, 4'b0100);
    check("R6 c0", active(), 1);
    tick(); check("R6 c1", active(), 1);
    tick(); check("R6 c2", active(), 0);
    tick(); check("R6 c3", active(), 0);
    check("R2 kept", stat_q, 4'b0100);

    // R3 read with simultaneous event
    evt_in = 4'b0010; stat_rd = 1'b1;
    tick();
    stat_rd = 1'b0; evt_in = '0;
    check("R3 collide", stat_q, 4'b0010);
    clear_all();
    check("R3 cleared", stat_q, 0);

    // R2 held event does not relatch after clear
    evt_in = 4'b1000; tick();
    check("R2 held set", stat_q, 4'b1000);
    stat_rd = 1'b1; tick(); stat_rd = 1'b0;
    tick();
    check("R2 held no relatch", stat_q, 0);
    clear_all();

    // R4 masked single pulse
    mask = 4'b0001;
    pulse_evt(4'b0001);
    check("R4 masked stat", stat_q, 4'b0001);
    check("R4 masked c0", active(), 0);
    tick(); check("R4 masked c1", active(), 0);
    clear_all();

    // R7 train sweep over periods
    mode = 2'd1; mask = 4'b0000;
    for (int p = 0; p < 8; p++) begin
      int pe;
      pe = (p < 2) ? 2 : p;
      period = 8'(p);
      clear_all();
      pulse_evt(4'b0001);
      for (int j = 0; j < 3 * pe; j++) begin
        check($sformatf("R7 p=%0d j=%0d", p, j), active(), ((j % pe) < (pe / 2)) ? 1 : 0);
        tick();
      end
      stat_rd = 1'b1; tick(); stat_rd = 1'b0;
      check("R7 stop", active(), 0);
      check("R3 train clr", stat_q, 0);
      for (int k = 0; k < pe + 1; k++) begin
        tick();
        check("R7 idle", active(), 0);
      end
    end

    // R4 masked train
    mask = 4'b1111;
    pulse_evt(4'b0110);
    check("R4 train stat", stat_q, 4'b0110);
    for (int k = 0; k < 6; k++) begin
      check("R4 train idle", active(), 0);
      tick();
    end
    clear_all();

    // R8 level sweep: every mask against every event pattern
    for (int m = 0; m < 16; m++) begin
      for (int e = 1; e < 16; e++) begin
        mode = (e[0]) ? 2'd2 : 2'd3;
        mask = 4'(m);
        clear_all();
        pulse_evt(4'(e));
        check("R2 level stat", stat_q, e);
        check($sformatf("R8 m=%0d e=%0d", m, e), active(), ((e & ~m & 15) != 0) ? 1 : 0);
        tick();
        check("R8 hold", active(), ((e & ~m & 15) != 0) ? 1 : 0);
      end
    end

    // R8 unmask while latched, then clear
    mode = 2'd2; mask = 4'b1111;
    clear_all();
    pulse_evt(4'b0100);
    check("R8 masked", active(), 0);
    mask = 4'b0000; tick();
    check("R8 unmasked", active(), 1);
    stat_rd = 1'b1; tick(); stat_rd = 1'b0;
    check("R8 cleared", active(), 0);

    // R5 and R9 polarity and pin drive
    for (int pl = 0; pl < 2; pl++) begin
      pol_hi = pl[0];
      od_en = 1'b0;
      clear_all();
      check("R5 idle", irq_o, pl ^ 1);
      check("R9 pp oe idle", pin_oe, 1);
      check("R9 pp out idle", pin_out, pl ^ 1);
      pulse_evt(4'b0001);
      check("R5 active", irq_o, pl);
      check("R9 pp out act", pin_out, pl);
      od_en = 1'b1; #1;
      check("R9 od oe act", pin_oe, 1);
      check("R9 od out act", pin_out, 0);
      clear_all();
      check("R9 od oe idle", pin_oe, 0);
      check("R9 od out idle", pin_out, 0);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule